// File: doc/BRIEF.md
# Descriptor List DMA Walker

This block steps through a linked list of buffer descriptors held in word-addressed memory on behalf of one network channel, for either receive or transmit. Software writes the address of the first descriptor while the channel is enabled, and the walker starts. Each descriptor is six 16-bit words: a flag word, a control word holding the high address bits, the low address word, a length word, and two status words. The walker reads these words one at a time over a simple memory request port.

The walker claims each descriptor by setting the two top bits of its flag word in memory. When the descriptor is marked valid, one of two things happens. A chain descriptor sends the walker to another location in the list. An ordinary descriptor hands its buffer address and word count to an external data mover. When the mover reports that it has finished, the walker writes the segment's completion status back into the descriptor and moves on to the next one, six words further along.

The walk ends at the first descriptor that is not marked valid. The walker then flags the list as invalid and waits for a new list address. A software reset returns it to idle from any state.

Top module: `desc_walker`

## Requirements
- R1: After reset the walker is idle. No memory request is pending, and the list-invalid flag and the interrupt flag are both 0.
- R2: A list address written while the channel is enabled starts a walk. The first memory request is a read of that exact address. A list address written while the channel is disabled is ignored: the walker stays idle and issues no request.
- R3: Right after reading a descriptor's flag word (offset 0), the walker writes the same value with bits 15 and 14 set back to the same address.
- R4: When bit 15 (the valid bit) of the control word (offset 1) is 0, the walker sets the list-invalid flag and returns to idle. It starts no transfer and writes no status.
- R5: When the valid bit and bit 14 (the chain bit) are both 1, the next descriptor is read at the 22-bit address formed from control bits 5:0 (high part) and the word at offset 2 (low part). No transfer is started for a chain descriptor.
- R6: For a valid descriptor that is not a chain, the walker pulses xfer_start once. xfer_addr carries the 22-bit buffer address, and xfer_words carries the two's-complement negation of the length word (offset 3).
- R7: When the mover reports done, the walker writes status word 1 at offset 4 and then status word 2 at offset 5. In status word 1, bit 15 is 1 if the segment is not the last of its packet, bit 14 is the error flag, and bits 10:8 are received-length bits 10:8. Status word 2 bits 7:0 are received-length bits 7:0. All other bits are 0.
- R8: After the status writes for a descriptor, the walker reads the next descriptor at the old descriptor address plus 6.
- R9: The interrupt flag is set when a descriptor's status writes complete, but only if interrupts are enabled at that moment. Otherwise it stays unchanged.
- R10: A software reset pulse returns the walker to idle in the next cycle and clears both the list-invalid flag and the interrupt flag.
- R11: The memory port has at most one access in flight. A request is held with a stable address until it is accepted. After a read is accepted, no new request is issued until its data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse |
| chan_en | input | 1 | Channel enable; gates list starts |
| irq_en | input | 1 | Interrupt enable |
| base_wr | input | 1 | List address write strobe |
| base_addr | input | ADDR_W | Word address of the first descriptor |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| xfer_start | output | 1 | One-cycle start pulse to the data mover |
| xfer_addr | output | ADDR_W | Buffer address for the mover |
| xfer_words | output | 16 | Buffer size in words |
| xfer_done | input | 1 | Mover finished the segment |
| xfer_last | input | 1 | Segment ends the packet |
| xfer_err | input | 1 | Segment had an error |
| xfer_len | input | LEN_W | Received length reported by the mover |
| busy | output | 1 | Walker is not idle |
| list_invalid | output | 1 | Walk stopped on a descriptor not marked valid |
| irq_flag | output | 1 | Latched completion interrupt |

## Verification
The bench builds the walker with its defaults: 22-bit addresses, an 11-bit received length and the receive variant. Because the address is 22 bits, the bench can place a chain target above the first 64K words, so the high address bits taken from the control word are actually checked. The receive variant fills in the split length fields, which lets every status bit be compared. The memory model withholds ready on every third cycle, so the bench also sees requests held through stalls.

// File: rtl/dw_pkg.sv
// Shared constants and the walker state type.
// Assumes 16-bit memory words and six-word descriptors.
package dw_pkg;
    localparam int WORD_W     = 16;
    localparam int DESC_WORDS = 6;
    localparam int OFF_FLAG   = 0;
    localparam int OFF_CTL    = 1;
    localparam int OFF_ALO    = 2;
    localparam int OFF_LEN    = 3;
    localparam int OFF_ST1    = 4;
    localparam int OFF_ST2    = 5;
    localparam int VALID_BIT  = 15;
    localparam int CHAIN_BIT  = 14;
    localparam logic [WORD_W-1:0] CLAIM_MASK = 16'hC000;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_FLAG, S_WR_FLAG, S_RD_CTL, S_RD_ALO, S_RD_LEN,
        S_DECIDE, S_XFER, S_XWAIT, S_WR_ST1, S_WR_ST2
    } walk_state_t;
endpackage

// File: rtl/dw_desc_decode.sv
// Decodes the control, address-low and length words of a descriptor.
// Assumes ADDR_W is between 17 and 30 so the high bits fit below the chain bit.
module dw_desc_decode
    import dw_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] alo_word,
    input  logic [WORD_W-1:0] len_word,
    output logic              is_valid,
    output logic              is_chain,
    output logic [ADDR_W-1:0] target,
    output logic [WORD_W-1:0] words
);
    localparam int HI_W = ADDR_W - WORD_W;

    // Field extraction and length negation.
    always_comb begin
        is_valid = ctl_word[VALID_BIT];
        is_chain = ctl_word[CHAIN_BIT];
        target   = {ctl_word[HI_W-1:0], alo_word};
        words    = (~len_word) + 16'd1;
    end
endmodule

// File: rtl/dw_status_pack.sv
// Builds the two completion status words from the mover's report.
// RX_CHAN selects whether the received length is encoded.
module dw_status_pack
    import dw_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter bit RX_CHAN = 1'b1
) (
    input  logic             seg_last,
    input  logic             seg_err,
    input  logic [LEN_W-1:0] seg_len,
    output logic [WORD_W-1:0] st1,
    output logic [WORD_W-1:0] st2
);
    localparam int LO_W = 8;
    localparam int HI_W = LEN_W - LO_W;

    generate
        if (RX_CHAN) begin : g_rx
            // Receive: length split across both words.
            always_comb begin
                st1 = '0;
                st1[15] = ~seg_last;
                st1[14] = seg_err;
                st1[LO_W +: HI_W] = seg_len[LEN_W-1:LO_W];
                st2 = {{(WORD_W-LO_W){1'b0}}, seg_len[LO_W-1:0]};
            end
        end else begin : g_tx
            // Transmit: only segment and error flags.
            always_comb begin
                st1 = '0;
                st1[15] = ~seg_last;
                st1[14] = seg_err;
                st2 = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/dw_flags.sv
// Holds the list-invalid and interrupt flags.
// Software reset has priority over set events.
module dw_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_invalid,
    input  logic set_done,
    input  logic irq_en,
    output logic list_invalid,
    output logic irq_flag
);
    // Sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            list_invalid <= 1'b0;
            irq_flag     <= 1'b0;
        end else begin
            if (set_invalid)
                list_invalid <= 1'b1;
            if (set_done && irq_en)
                irq_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/desc_walker.sv
// Walks a chained descriptor list: claims, decodes, dispatches to a mover,
// writes status back. Assumes a memory that answers reads some cycles
// after acceptance and a mover that reports done once per start.
module desc_walker
    import dw_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int LEN_W   = 11,
    parameter bit RX_CHAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              chan_en,
    input  logic              irq_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [15:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [15:0]       mem_rsp_data,
    output logic              xfer_start,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [15:0]       xfer_words,
    input  logic              xfer_done,
    input  logic              xfer_last,
    input  logic              xfer_err,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              busy,
    output logic              list_invalid,
    output logic              irq_flag
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_WORDS);

    walk_state_t       state;
    logic              wait_rsp;
    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] flag_q, ctl_q, alo_q, len_q;
    logic              last_q, err_q;
    logic [LEN_W-1:0]  rlen_q;
    logic [2:0]        off;
    logic              accept, rsp_take, is_mem, set_invalid, set_done;
    logic              d_valid, d_chain;
    logic [ADDR_W-1:0] d_target;
    logic [WORD_W-1:0] d_words, st1, st2;

    dw_desc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ctl_word(ctl_q), .alo_word(alo_q), .len_word(len_q),
        .is_valid(d_valid), .is_chain(d_chain), .target(d_target), .words(d_words)
    );

    dw_status_pack #(.LEN_W(LEN_W), .RX_CHAN(RX_CHAN)) u_st (
        .seg_last(last_q), .seg_err(err_q), .seg_len(rlen_q), .st1(st1), .st2(st2)
    );

    dw_flags u_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_invalid(set_invalid), .set_done(set_done), .irq_en(irq_en),
        .list_invalid(list_invalid), .irq_flag(irq_flag)
    );

    // Memory request generation from the current state.
    always_comb begin
        is_mem = 1'b1;
        mem_req_we = 1'b0;
        mem_req_wdata = '0;
        off = 3'(OFF_FLAG);
        case (state)
            S_RD_FLAG: off = 3'(OFF_FLAG);
            S_WR_FLAG: begin off = 3'(OFF_FLAG); mem_req_we = 1'b1; mem_req_wdata = flag_q | CLAIM_MASK; end
            S_RD_CTL:  off = 3'(OFF_CTL);
            S_RD_ALO:  off = 3'(OFF_ALO);
            S_RD_LEN:  off = 3'(OFF_LEN);
            S_WR_ST1:  begin off = 3'(OFF_ST1); mem_req_we = 1'b1; mem_req_wdata = st1; end
            S_WR_ST2:  begin off = 3'(OFF_ST2); mem_req_we = 1'b1; mem_req_wdata = st2; end
            default:   is_mem = 1'b0;
        endcase
        mem_req_valid = is_mem && !wait_rsp;
        mem_req_addr  = ptr + ADDR_W'(off);
    end

    // Handshake and event decode.
    always_comb begin
        accept      = mem_req_valid && mem_req_ready;
        rsp_take    = wait_rsp && mem_rsp_valid;
        set_invalid = (state == S_DECIDE) && !d_valid;
        set_done    = (state == S_WR_ST2) && accept;
        busy        = (state != S_IDLE);
        xfer_start  = (state == S_XFER);
        xfer_addr   = d_target;
        xfer_words  = d_words;
    end

    // Walker sequencing, pointer and captured descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wait_rsp <= 1'b0;
            ptr      <= '0;
            flag_q   <= '0;
            ctl_q    <= '0;
            alo_q    <= '0;
            len_q    <= '0;
            last_q   <= 1'b0;
            err_q    <= 1'b0;
            rlen_q   <= '0;
        end else if (soft_rst) begin
            state    <= S_IDLE;
            wait_rsp <= 1'b0;
        end else begin
            if (accept && !mem_req_we)
                wait_rsp <= 1'b1;
            if (rsp_take)
                wait_rsp <= 1'b0;
            case (state)
                S_IDLE: if (base_wr && chan_en) begin
                    ptr   <= base_addr;
                    state <= S_RD_FLAG;
                end
                S_RD_FLAG: if (rsp_take) begin flag_q <= mem_rsp_data; state <= S_WR_FLAG; end
                S_WR_FLAG: if (accept) state <= S_RD_CTL;
                S_RD_CTL:  if (rsp_take) begin ctl_q <= mem_rsp_data; state <= S_RD_ALO; end
                S_RD_ALO:  if (rsp_take) begin alo_q <= mem_rsp_data; state <= S_RD_LEN; end
                S_RD_LEN:  if (rsp_take) begin len_q <= mem_rsp_data; state <= S_DECIDE; end
                S_DECIDE: begin
                    if (!d_valid)
                        state <= S_IDLE;
                    else if (d_chain) begin
                        ptr   <= d_target;
                        state <= S_RD_FLAG;
                    end else
                        state <= S_XFER;
                end
                S_XFER: state <= S_XWAIT;
                S_XWAIT: if (xfer_done) begin
                    last_q <= xfer_last;
                    err_q  <= xfer_err;
                    rlen_q <= xfer_len;
                    state  <= S_WR_ST1;
                end
                S_WR_ST1: if (accept) state <= S_WR_ST2;
                S_WR_ST2: if (accept) begin
                    ptr   <= ptr + STEP;
                    state <= S_RD_FLAG;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dw_checker.sv
// Protocol and flag checks for the descriptor walker, bound to its ports.
module dw_checker #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              irq_en,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              busy,
    input logic              list_invalid,
    input logic              irq_flag
);
    logic rd_pend;

    // Tracks a read accepted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            rd_pend <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_we)
            rd_pend <= 1'b1;
        else if (mem_rsp_valid)
            rd_pend <= 1'b0;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !soft_rst) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R11
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !mem_req_valid); // R11
    AST_STOP_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(list_invalid) |-> !busy); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_en)); // R9
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !list_invalid && !irq_flag)); // R10
endmodule

bind desc_walker dw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_en(irq_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .busy(busy),
    .list_invalid(list_invalid), .irq_flag(irq_flag)
);

// File: tb/desc_walker_test.sv
// Scoreboard bench: expected writes and transfers are queued by driver
// tasks and consumed by the memory and mover models as the walker acts.
module desc_walker_test;
    localparam int AW = 22;
    localparam int LW = 11;

    typedef struct { logic [AW-1:0] a; logic [15:0] d; string tag; } wr_t;
    typedef struct { logic [AW-1:0] a; logic [15:0] w; } xf_t;
    typedef struct { logic [LW-1:0] len; logic err; logic last; } dn_t;

    logic clk = 0, rst_n = 0, soft_rst = 0, chan_en = 0, irq_en = 0, base_wr = 0;
    logic [AW-1:0] base_addr = '0;
    logic mem_req_valid, mem_req_we, mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [15:0] mem_req_wdata, mem_rsp_data = '0;
    logic xfer_start, xfer_done = 0, xfer_last = 0, xfer_err = 0;
    logic [AW-1:0] xfer_addr;
    logic [15:0] xfer_words;
    logic [LW-1:0] xfer_len = '0;
    logic busy, list_invalid, irq_flag;

    logic [15:0] mem [int];
    wr_t exp_wr[$];
    xf_t exp_xf[$];
    dn_t done_q[$];
    int checks = 0, fails = 0, req_count = 0, xfer_seen = 0;

    always #10 clk = ~clk;

    desc_walker #(.ADDR_W(AW), .LEN_W(LW), .RX_CHAN(1'b1)) uut (.*);

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(int a);
        return mem.exists(a) ? mem[a] : 16'h0;
    endfunction

    task automatic put_desc(int a, logic [15:0] f, logic [15:0] c, logic [15:0] lo, logic [15:0] ln);
        mem[a] = f; mem[a+1] = c; mem[a+2] = lo; mem[a+3] = ln; mem[a+4] = '0; mem[a+5] = '0;
    endtask

    task automatic exp_claim(int a, string tag);
        exp_wr.push_back('{a: AW'(a), d: rd(a) | 16'hC000, tag: tag});
    endtask

    task automatic exp_buffer(int a, logic [AW-1:0] ba, logic [15:0] words,
                              logic [LW-1:0] len, logic err, logic last);
        logic [15:0] s1, s2;
        exp_xf.push_back('{a: ba, w: words});
        done_q.push_back('{len: len, err: err, last: last});
        s1 = {~last, err, 3'b000, len[10:8], 8'h00};
        s2 = {8'h00, len[7:0]};
        exp_wr.push_back('{a: AW'(a + 4), d: s1, tag: "R7"});
        exp_wr.push_back('{a: AW'(a + 5), d: s2, tag: "R7"});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic start_list(logic [AW-1:0] a);
        @(negedge clk);
        base_addr = a; base_wr = 1;
        @(negedge clk);
        base_wr = 0;
    endtask

    // Memory model: accepts requests, stalls every third cycle, checks writes.
    initial begin : mem_model
        logic acc, w;
        logic [AW-1:0] a;
        logic [15:0] d;
        int cyc;
        wr_t e;
        cyc = 0;
        forever begin
            @(posedge clk);
            acc = mem_req_valid && mem_req_ready;
            a = mem_req_addr; w = mem_req_we; d = mem_req_wdata;
            #1;
            if (acc) req_count++;
            if (acc && w) begin
                mem[int'(a)] = d;
                if (exp_wr.size() == 0)
                    chk(0, "R3", "unexpected write", {10'b0, a}, 0);
                else begin
                    e = exp_wr.pop_front();
                    chk(e.a == a, e.tag, "write address", {10'b0, a}, {10'b0, e.a});
                    chk(e.d == d, e.tag, "write data", {16'b0, d}, {16'b0, e.d});
                end
            end
            mem_rsp_valid = acc && !w;
            mem_rsp_data  = rd(int'(a));
            cyc++;
            mem_req_ready = (cyc % 3 != 0);
        end
    end

    // Data mover stub: checks the start request, answers three cycles later.
    initial begin : mover_model
        logic st;
        logic [AW-1:0] a;
        logic [15:0] w;
        xf_t e;
        dn_t dn;
        forever begin
            @(posedge clk);
            st = xfer_start; a = xfer_addr; w = xfer_words;
            #1;
            if (st) begin
                xfer_seen++;
                if (exp_xf.size() == 0)
                    chk(0, "R5", "unexpected transfer", {10'b0, a}, 0);
                else begin
                    e = exp_xf.pop_front();
                    chk(e.a == a, "R6", "buffer address", {10'b0, a}, {10'b0, e.a});
                    chk(e.w == w, "R6", "buffer words", {16'b0, w}, {16'b0, e.w});
                end
                repeat (3) @(posedge clk);
                #1;
                dn = done_q.pop_front();
                xfer_len = dn.len; xfer_err = dn.err; xfer_last = dn.last; xfer_done = 1;
                @(posedge clk);
                #1;
                xfer_done = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Stimulus sequence.
    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(mem_req_valid == 0, "R1", "request after reset", mem_req_valid, 0);
        chk(list_invalid == 0, "R1", "invalid after reset", list_invalid, 0);
        chk(irq_flag == 0, "R1", "irq after reset", irq_flag, 0);

        // R2: start ignored while disabled.
        start_list(22'h000100);
        repeat (10) @(negedge clk);
        chk(busy == 0, "R2", "busy while disabled", busy, 0);
        chk(req_count == 0, "R2", "requests while disabled", req_count, 0);

        // Main list: buffer, then chain to a high address, buffer, then invalid.
        put_desc(32'h100, 16'h1234, 16'h8002, 16'h1234, 16'hFFFC);
        put_desc(32'h106, 16'h0000, 16'hC003, 16'h0040, 16'h0000);
        put_desc(32'h30040, 16'h0000, 16'h8000, 16'h8000, 16'hFFFF);
        put_desc(32'h30046, 16'h0001, 16'h0000, 16'h0000, 16'h0000);
        exp_claim(32'h100, "R3");
        exp_buffer(32'h100, 22'h021234, 16'd4, 11'h5A3, 1'b0, 1'b0);
        exp_claim(32'h106, "R8");
        exp_claim(32'h30040, "R5");
        exp_buffer(32'h30040, 22'h008000, 16'd1, 11'h07F, 1'b1, 1'b1);
        exp_claim(32'h30046, "R4");
        chan_en = 1; irq_en = 1;
        @(negedge clk);
        base_addr = 22'h000100; base_wr = 1;
        @(negedge clk);
        base_wr = 0;
        chk(mem_req_valid && !mem_req_we, "R2", "first request is a read", mem_req_valid, 1);
        chk(mem_req_addr == 22'h000100, "R2", "first request address", {10'b0, mem_req_addr}, 32'h100);
        wait_idle();
        chk(list_invalid == 1, "R4", "invalid after walk", list_invalid, 1);
        chk(irq_flag == 1, "R9", "irq with enable", irq_flag, 1);
        chk(xfer_seen == 2, "R5", "transfers (chain takes none)", xfer_seen, 2);
        chk(exp_wr.size() == 0, "R8", "writes left over", exp_wr.size(), 0);

        // R10: software reset clears flags.
        @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        chk(list_invalid == 0, "R10", "invalid after soft reset", list_invalid, 0);
        chk(irq_flag == 0, "R10", "irq after soft reset", irq_flag, 0);
        chk(busy == 0, "R10", "busy after soft reset", busy, 0);

        // R9: completion with interrupts disabled leaves the flag clear.
        irq_en = 0;
        put_desc(32'h200, 16'h0000, 16'h8001, 16'h0000, 16'hFED4);
        put_desc(32'h206, 16'h0000, 16'h4000, 16'h0000, 16'h0000);
        exp_claim(32'h200, "R3");
        exp_buffer(32'h200, 22'h010000, 16'd300, 11'h400, 1'b0, 1'b1);
        exp_claim(32'h206, "R4");
        start_list(22'h000200);
        wait_idle();
        chk(irq_flag == 0, "R9", "irq without enable", irq_flag, 0);
        chk(list_invalid == 1, "R4", "invalid second list", list_invalid, 1);
        chk(xfer_seen == 3, "R6", "transfer count", xfer_seen, 3);
        chk(exp_wr.size() == 0, "R7", "writes left over", exp_wr.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule